// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block sits between a host and an embedded controller's private register space. The host sees two byte-wide ports, one for commands and one for data, plus a status byte that shows whether the input byte is still waiting to be taken, whether a reply byte is waiting to be collected, and whether any controller event is pending. An internal engine takes each incoming byte on the clock after it arrives. It follows the byte's position inside the current command and either stores to or reads from a small internal register array, or returns a reply byte.

The block has one interrupt line towards the host, and it carries a one-cycle pulse. The pulse is not raised on every flag change. For each command, the byte position decides whether the pulse goes out when the input byte is taken, when a reply byte is posted, or not at all. The pulse also goes out when the event-pending flag first becomes set. The host answers that pulse with a Query command, which returns and retires the lowest-numbered pending event.

Top module: `ec_mailbox`

## Requirements
- R1: While reset is held and after it is released, the status byte, the data output and the interrupt line are all zero.
- R2: The status byte layout is: bit 0 reply-full, bit 1 input-full, bit 3 last-byte-was-command, bit 4 burst mode, bit 5 event pending, and all other bits zero. A command-port write sets input-full and the command bit. A data-port write sets input-full and clears the command bit. Any write that arrives while input-full is set is dropped.
- R3: A byte that has been written is taken on the next clock edge, and input-full clears on that edge.
- R4: For Write (opcode 0x81), the header, the address byte and the data byte each give an interrupt pulse when taken. The data byte is stored at the address modulo the array depth (default 16).
- R5: For Read (opcode 0x80), the header gives a pulse when taken. Taking the address byte gives no pulse of its own. On the same edge it posts the stored byte with reply-full set, and that posting gives one pulse.
- R6: For Query (opcode 0x84), the header gives no pulse of its own. The block posts the lowest pending event number (event input bit i reports as i+1, and 0 when none is pending), clears that pending bit, and gives a pulse for the reply.
- R7: Burst Enable (opcode 0x82) posts the reply byte 0x90, sets the burst bit and gives a pulse for the reply. Burst Disable (opcode 0x83) clears the burst bit and gives a pulse when taken.
- R8: An unknown opcode, or a data byte that arrives outside a command, is taken without a pulse and without a reply.
- R9: A host read of the data port clears reply-full. The data output keeps its value until the next reply.
- R10: Event input bits are ORed into a pending set, and the event-pending bit shows whether that set is non-empty. A pulse is raised when event-pending goes from clear to set, and no pulse is raised for events that arrive while it is already set.
- R11: Every pulse coincides with either input-full clearing or event-pending rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd_wr | input | 1 | Host writes host_wdata to the command port |
| host_data_wr | input | 1 | Host writes host_wdata to the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_data_rd | input | 1 | Host reads the data port |
| event_set | input | NUM_EVT | Controller-side event raise pulses, one bit per event |
| host_rdata | output | 8 | Data port read value |
| host_status | output | 8 | Status byte |
| sci | output | 1 | One-cycle interrupt pulse to the host |

## Verification
The embedded assertions check four things on every cycle. Input-full never lasts more than one cycle, and a write that arrives while it is set changes nothing. Reply-full only falls after a host read. Every interrupt pulse lines up with a byte being taken or with event-pending rising. They cannot show which byte positions interrupt, what value a reply carries, or whether a stored byte lands at the right address. The bench shows those by walking complete Write, Read, Query and Burst transactions, address wrap, unknown opcodes and stray data. It also runs a multi-event Query drain and sends a write back-to-back with a busy input.

// File: rtl/ec_mailbox.sv
module ec_mailbox #(
  parameter int ADDR_W  = 4,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_cmd_wr,
  input  logic               host_data_wr,
  input  logic [7:0]         host_wdata,
  input  logic               host_data_rd,
  input  logic [NUM_EVT-1:0] event_set,
  output logic [7:0]         host_rdata,
  output logic [7:0]         host_status,
  output logic               sci
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] OP_RD = 8'h80, OP_WR = 8'h81, OP_BE = 8'h82,
                         OP_BD = 8'h83, OP_QR = 8'h84, BURST_ACK = 8'h90;

  typedef enum logic [1:0] {PH_IDLE, PH_RD_ADDR, PH_WR_ADDR, PH_WR_DATA} phase_t;

  phase_t              phase_q, nx_phase;
  logic                ibf_q, obf_q, cmd_q, burst_q, sci_q;
  logic [7:0]          byte_q, dout_q;
  logic [ADDR_W-1:0]   addr_q, nx_addr;
  logic [NUM_EVT-1:0]  pend_q, pend_d, evt_clr;
  logic [7:0]          mem [DEPTH];
  logic [7:0]          evt_num, ret_byte;
  logic                byte_sci, ret_val, wr_mem, burst_on, burst_off, qry, evt_rise;

  always_comb begin
    evt_num = '0;
    evt_clr = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--)
      if (pend_q[i]) begin
        evt_num = 8'(i + 1);
        evt_clr = '0;
        evt_clr[i] = 1'b1;
      end
  end

  always_comb begin
    nx_phase  = phase_q;
    nx_addr   = addr_q;
    byte_sci  = 1'b0;
    ret_val   = 1'b0;
    ret_byte  = '0;
    wr_mem    = 1'b0;
    burst_on  = 1'b0;
    burst_off = 1'b0;
    qry       = 1'b0;
    if (ibf_q) begin
      if (cmd_q) begin
        nx_phase = PH_IDLE;
        case (byte_q)
          OP_RD: begin byte_sci = 1'b1; nx_phase = PH_RD_ADDR; end
          OP_WR: begin byte_sci = 1'b1; nx_phase = PH_WR_ADDR; end
          OP_BE: begin ret_val = 1'b1; ret_byte = BURST_ACK; burst_on = 1'b1; end
          OP_BD: begin byte_sci = 1'b1; burst_off = 1'b1; end
          OP_QR: begin ret_val = 1'b1; ret_byte = evt_num; qry = 1'b1; end
          default: ;
        endcase
      end else begin
        case (phase_q)
          PH_RD_ADDR: begin
            ret_val  = 1'b1;
            ret_byte = mem[byte_q[ADDR_W-1:0]];
            nx_phase = PH_IDLE;
          end
          PH_WR_ADDR: begin
            byte_sci = 1'b1;
            nx_addr  = byte_q[ADDR_W-1:0];
            nx_phase = PH_WR_DATA;
          end
          PH_WR_DATA: begin
            byte_sci = 1'b1;
            wr_mem   = 1'b1;
            nx_phase = PH_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign pend_d   = (pend_q & ~(qry ? evt_clr : '0)) | event_set;
  assign evt_rise = (pend_q == '0) && (pend_d != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      ibf_q   <= 1'b0;
      obf_q   <= 1'b0;
      cmd_q   <= 1'b0;
      burst_q <= 1'b0;
      sci_q   <= 1'b0;
      byte_q  <= '0;
      dout_q  <= '0;
      pend_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      phase_q <= nx_phase;
      addr_q  <= nx_addr;
      pend_q  <= pend_d;
      sci_q   <= byte_sci | ret_val | evt_rise;
      if (ibf_q) ibf_q <= 1'b0;
      else if (host_cmd_wr || host_data_wr) begin
        ibf_q  <= 1'b1;
        byte_q <= host_wdata;
        cmd_q  <= host_cmd_wr;
      end
      if (ret_val) begin
        obf_q  <= 1'b1;
        dout_q <= ret_byte;
      end else if (host_data_rd) obf_q <= 1'b0;
      if (burst_on) burst_q <= 1'b1;
      else if (burst_off) burst_q <= 1'b0;
      if (wr_mem) mem[addr_q] <= byte_q;
    end
  end

  assign host_rdata  = dout_q;
  assign host_status = {2'b00, |pend_q, burst_q, cmd_q, 1'b0, ibf_q, obf_q};
  assign sci         = sci_q;

  AST_IBF_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    host_status[1] |=> !host_status[1]); // R3
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status[1] && (host_cmd_wr || host_data_wr)) |=> (!host_status[1] && $stable(host_status[3]))); // R2
  AST_OBF_HOST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_status[0]) |-> $past(host_data_rd)); // R9
  AST_EVT_SCI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_status[5]) |-> sci); // R10
  AST_SCI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> ($fell(host_status[1]) || $rose(host_status[5]))); // R11
endmodule

// File: tb/ec_mailbox_tb.sv
module ec_mailbox_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cmd_wr = 1'b0, host_data_wr = 1'b0, host_data_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] event_set = '0;
  logic [7:0] host_rdata, host_status;
  logic       sci;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ec_mailbox #(.ADDR_W(4), .NUM_EVT(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_cmd_wr(host_cmd_wr), .host_data_wr(host_data_wr),
    .host_wdata(host_wdata), .host_data_rd(host_data_rd), .event_set(event_set),
    .host_rdata(host_rdata), .host_status(host_status), .sci(sci));

  // kind: 0 command write, 1 data write, 2 data read | byte | sci | status | rdata
  localparam int NV = 19;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 8'h81, 1'b1, 8'h08, 8'h00},  // R4 header
    {2'd1, 8'h05, 1'b1, 8'h00, 8'h00},  // R4 address
    {2'd1, 8'hA7, 1'b1, 8'h00, 8'h00},  // R4 data
    {2'd0, 8'h80, 1'b1, 8'h08, 8'h00},  // R5 header
    {2'd1, 8'h05, 1'b1, 8'h01, 8'hA7},  // R5 address -> reply
    {2'd2, 8'h00, 1'b0, 8'h00, 8'hA7},  // R9
    {2'd0, 8'h82, 1'b1, 8'h19, 8'h90},  // R7 burst on
    {2'd2, 8'h00, 1'b0, 8'h18, 8'h90},  // R9
    {2'd0, 8'h83, 1'b1, 8'h08, 8'h90},  // R7 burst off
    {2'd0, 8'h77, 1'b0, 8'h08, 8'h90},  // R8 unknown opcode
    {2'd1, 8'h12, 1'b0, 8'h00, 8'h90},  // R8 stray data
    {2'd0, 8'h84, 1'b1, 8'h09, 8'h00},  // R6 empty query
    {2'd2, 8'h00, 1'b0, 8'h08, 8'h00},  // R9
    {2'd0, 8'h81, 1'b1, 8'h08, 8'h00},  // R4
    {2'd1, 8'h15, 1'b1, 8'h00, 8'h00},  // R4 address wraps to 5
    {2'd1, 8'h3C, 1'b1, 8'h00, 8'h00},  // R4
    {2'd0, 8'h80, 1'b1, 8'h08, 8'h00},  // R5
    {2'd1, 8'h05, 1'b1, 8'h01, 8'h3C},  // R5 reads wrapped write
    {2'd2, 8'h00, 1'b0, 8'h00, 8'h3C}   // R9
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] kind, input logic [7:0] b);
    @(negedge clk);
    host_wdata   = b;
    host_cmd_wr  = (kind == 2'd0);
    host_data_wr = (kind == 2'd1);
    host_data_rd = (kind == 2'd2);
    @(negedge clk);
    host_cmd_wr = 1'b0; host_data_wr = 1'b0; host_data_rd = 1'b0;
    if (kind != 2'd2) begin
      chk("R2 input-full after write", {7'd0, host_status[1]}, 8'h01);
      @(negedge clk);
    end
  endtask

  task automatic evt(input logic [7:0] mask, input logic exp_sci, input logic [7:0] exp_st);
    @(negedge clk);
    event_set = mask;
    @(negedge clk);
    event_set = '0;
    chk("R10 event sci", {7'd0, sci}, {7'd0, exp_sci});
    chk("R10 event status", host_status, exp_st);
  endtask

  task automatic txn(input logic [1:0] kind, input logic [7:0] b, input logic exp_sci,
                     input logic [7:0] exp_st, input logic [7:0] exp_rd, input string tag);
    op(kind, b);
    chk({tag, " sci"}, {7'd0, sci}, {7'd0, exp_sci});
    chk({tag, " status"}, host_status, exp_st);
    chk({tag, " rdata"}, host_rdata, exp_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status in reset", host_status, 8'h00);
    chk("R1 sci in reset", {7'd0, sci}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", host_status, 8'h00);
    chk("R1 rdata after reset", host_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][26:25], VEC[i][24:17]);
      chk($sformatf("R4-R9 vec%0d sci", i), {7'd0, sci}, {7'd0, VEC[i][16]});
      chk($sformatf("R3 vec%0d status", i), host_status, VEC[i][15:8]);
      chk($sformatf("R5 vec%0d rdata", i), host_rdata, VEC[i][7:0]);
    end

    // R10: events and query drain (R6)
    evt(8'h24, 1'b1, 8'h20);
    @(negedge clk);
    chk("R11 sci is one cycle", {7'd0, sci}, 8'h00);
    evt(8'h01, 1'b0, 8'h20);
    txn(2'd0, 8'h84, 1'b1, 8'h29, 8'h01, "R6 query lowest");
    txn(2'd2, 8'h00, 1'b0, 8'h28, 8'h01, "R9 read");
    txn(2'd0, 8'h84, 1'b1, 8'h29, 8'h03, "R6 query next");
    txn(2'd2, 8'h00, 1'b0, 8'h28, 8'h03, "R9 read");
    txn(2'd0, 8'h84, 1'b1, 8'h09, 8'h06, "R6 query last");
    txn(2'd2, 8'h00, 1'b0, 8'h08, 8'h06, "R9 read");
    txn(2'd0, 8'h84, 1'b1, 8'h09, 8'h00, "R6 query none");
    txn(2'd2, 8'h00, 1'b0, 8'h08, 8'h00, "R9 read");
    evt(8'h80, 1'b1, 8'h28);

    // R2: data write back-to-back with a busy input is dropped
    @(negedge clk);
    host_wdata = 8'h81; host_cmd_wr = 1'b1;
    @(negedge clk);
    host_cmd_wr = 1'b0; host_wdata = 8'h55; host_data_wr = 1'b1;
    @(negedge clk);
    host_data_wr = 1'b0;
    chk("R2 busy write dropped status", host_status, 8'h28);
    chk("R4 header sci", {7'd0, sci}, 8'h01);
    @(negedge clk);
    chk("R2 no second byte", host_status, 8'h28);
    txn(2'd1, 8'h06, 1'b1, 8'h20, 8'h00, "R4 address");
    txn(2'd1, 8'h11, 1'b1, 8'h20, 8'h00, "R4 data");
    txn(2'd0, 8'h80, 1'b1, 8'h28, 8'h00, "R5 header");
    txn(2'd1, 8'h06, 1'b1, 8'h21, 8'h11, "R2 dropped byte not used");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule